// File: doc/BRIEF.md
# Character-Synchronous Serial Transmitter with Automatic CRC Trailer

This block serializes bytes for a byte-synchronous serial link. A host places each data byte in a one-entry holding register and watches a data-request output. That output lets a CPU loop or a DMA engine move a whole block of bytes without polling any status. The line is paced by a bit clock enable. Each character is eight bits long and goes out least significant bit first.

When no data is waiting, the transmitter fills the line with a programmable sync character, so every message is preceded by a run of syncs. A CRC-16 is built over the data bytes that the host marks for inclusion. The host ends a message by clearing an end-of-message latch after it writes the last byte. When the holding register then runs dry, the transmitter appends the two CRC bytes. It then sets the latch again and falls back to sync fill. A running link never stops or leaves a gap between characters.

Top module: `bsync_tx`

## Requirements
- R1: Out of reset, `txd` is 1, `tx_busy` is 0, `eom_flag` is 1 and `data_req` is 0. The sync character resets to 0x16.
- R2: When `tx_en` is high, the holding register is empty and `eom_flag` is 1, the sync character is sent back to back with no gap.
- R3: The CRC register is preset to zero. Each accumulated byte is processed bit by bit, least significant bit first: feedback = bit XOR crc[15], then crc = (crc << 1) XOR (feedback ? 0x8005 : 0). The CRC is sent as the high byte crc[15:8] and then the low byte, each one least significant bit first. The register returns to zero once the high byte is loaded. Sync characters never enter the CRC, and neither do bytes that are sent while `crc_en` is low.
- R4: `data_req` is high exactly when `tx_en` is high and the holding register is empty. It is low in the cycle after an accepted write.
- R5: Data bytes go out in the order they were written, least significant bit first. Each bit lasts from one `bit_en` pulse to the next. `txd` changes only in the cycle after a `bit_en` pulse.
- R6: `eom_reset` clears `eom_flag`. When a character is needed, the holding register is empty and `eom_flag` is 0, the two CRC bytes are sent.
- R7: When the second CRC byte starts, `eom_flag` sets and `status_chg` is high for exactly one cycle. After that, the line returns to sync fill. Each message gives exactly one pulse.
- R8: A byte written with `wr_crc_incl` = 0 is transmitted but left out of the CRC.
- R9: A write while the holding register is full is ignored. If the register runs empty while `eom_flag` is 1, only sync characters follow, and no CRC is sent.
- R10: When `tx_en` goes low, the character in flight is completed. After that, `tx_busy` is 0 and `txd` stays 1.
- R11: A pulse on `wr_sync_en` loads `wr_sync` as the new fill character. That value is used by every fill sent afterwards.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| bit_en | input | 1 | One-cycle pulse per serial bit time |
| tx_en | input | 1 | Transmitter enable |
| crc_en | input | 1 | Allows CRC accumulation of data bytes as they are loaded |
| wr_data_en | input | 1 | Write strobe for the holding register |
| wr_data | input | 8 | Data byte to write |
| wr_crc_incl | input | 1 | 1 = include this byte in the CRC |
| wr_sync_en | input | 1 | Write strobe for the sync character |
| wr_sync | input | 8 | New sync character |
| eom_reset | input | 1 | Clears the end-of-message latch |
| data_req | output | 1 | Holding register can accept a byte |
| eom_flag | output | 1 | End-of-message/underrun latch: 1 = underrun gives sync fill |
| status_chg | output | 1 | One-cycle pulse when the CRC trailer completes its load |
| tx_busy | output | 1 | A character is being shifted out |
| txd | output | 1 | Serial data out, 1 when idle |

## Verification
An accepted write drops `data_req` at the next clock edge. The bench therefore checks the flag half a cycle after that edge, before any later edge can let the shifter take the byte. Every serial bit is held from one `bit_en` edge to the next. The monitor samples `txd` at the falling edge of each cycle that carries `bit_en`, which is the final cycle of that bit. It assembles eight samples into a character and compares it with the head of the expected queue. The latch and the status pulse are observed at falling edges, one cycle after the edge that loads the second CRC byte, and the bench counts pulses per message rather than relying on a fixed cycle.

// File: rtl/bsync_pkg.sv
// Package: shared types for the sync transmitter.
// Assumes: nothing beyond the standard.
package bsync_pkg;
    // Source that feeds the shifter at a character boundary
    typedef enum logic [1:0] {
        SRC_SYNC   = 2'd0,
        SRC_DATA   = 2'd1,
        SRC_CRC_HI = 2'd2,
        SRC_CRC_LO = 2'd3
    } src_e;
endpackage

// File: rtl/bsync_hold.sv
// Module: one-entry transmit holding register.
// Does: captures a host byte with its CRC-include flag while empty, and
// empties when the shifter takes it. Assumes take is raised only when full.
module bsync_hold #(
    parameter int CHAR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [CHAR_W-1:0] wr_data,
    input  logic              wr_incl,
    input  logic              take,
    output logic              full,
    output logic [CHAR_W-1:0] data,
    output logic              incl
);
    // Purpose: fill on a write while empty, empty on take; writes while full drop
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            full <= 1'b0;
            data <= '0;
            incl <= 1'b0;
        end else if (take) begin
            full <= 1'b0;
        end else if (wr_en && !full) begin
            full <= 1'b1;
            data <= wr_data;
            incl <= wr_incl;
        end
    end
endmodule

// File: rtl/bsync_crc.sv
// Module: byte-wide CRC accumulator.
// Does: folds one byte per accumulate strobe into the register, bits taken
// LSB first, and clears to zero on clr. Assumes CRC_W >= 2.
module bsync_crc #(
    parameter int              CHAR_W = 8,
    parameter int              CRC_W  = 16,
    parameter logic [CRC_W-1:0] POLY  = 16'h8005
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              acc_en,
    input  logic [CHAR_W-1:0] acc_byte,
    input  logic              clr,
    output logic [CRC_W-1:0]  crc
);
    logic [CRC_W-1:0] crc_nxt;

    // Purpose: one step of the bitwise polynomial division per input bit
    always_comb begin
        crc_nxt = crc;
        for (int i = 0; i < CHAR_W; i++) begin
            if (acc_byte[i] ^ crc_nxt[CRC_W-1])
                crc_nxt = {crc_nxt[CRC_W-2:0], 1'b0} ^ POLY;
            else
                crc_nxt = {crc_nxt[CRC_W-2:0], 1'b0};
        end
    end

    // Purpose: hold the running CRC; clear has priority over accumulate
    always_ff @(posedge clk) begin
        if (!rst_n)
            crc <= '0;
        else if (clr)
            crc <= '0;
        else if (acc_en)
            crc <= crc_nxt;
    end
endmodule

// File: rtl/bsync_shift.sv
// Module: character shifter.
// Does: shifts a loaded character out LSB first, one bit per bit_en, and
// flags the boundary at which the next character must be supplied.
// Assumes bit_en is a single-cycle pulse.
module bsync_shift #(
    parameter int CHAR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bit_en,
    input  logic              tx_en,
    input  logic [CHAR_W-1:0] load_val,
    output logic              boundary,
    output logic              busy,
    output logic              txd
);
    localparam int CNT_W = (CHAR_W > 1) ? $clog2(CHAR_W) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(CHAR_W - 1);

    logic [CHAR_W-1:0] sh;
    logic [CNT_W-1:0]  cnt;

    // Purpose: a new character is due when idle or after the last bit
    assign boundary = bit_en && (!busy || (cnt == LAST));
    assign txd      = busy ? sh[0] : 1'b1;

    // Purpose: load, shift or go idle on each bit time
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sh   <= '1;
            cnt  <= '0;
            busy <= 1'b0;
        end else if (boundary) begin
            if (tx_en) begin
                sh   <= load_val;
                cnt  <= '0;
                busy <= 1'b1;
            end else begin
                busy <= 1'b0;
            end
        end else if (bit_en && busy) begin
            sh  <= {1'b1, sh[CHAR_W-1:1]};
            cnt <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/bsync_tx.sv
// Module: character-synchronous transmitter top.
// Does: chooses data, CRC trailer or sync fill at each character boundary,
// runs the end-of-message latch and drives request and status outputs.
// Assumes CRC width is twice the character width.
module bsync_tx #(
    parameter int                 CHAR_W    = 8,
    parameter logic [2*CHAR_W-1:0] CRC_POLY = 16'h8005,
    parameter logic [CHAR_W-1:0]  SYNC_INIT = 8'h16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bit_en,
    input  logic              tx_en,
    input  logic              crc_en,
    input  logic              wr_data_en,
    input  logic [CHAR_W-1:0] wr_data,
    input  logic              wr_crc_incl,
    input  logic              wr_sync_en,
    input  logic [CHAR_W-1:0] wr_sync,
    input  logic              eom_reset,
    output logic              data_req,
    output logic              eom_flag,
    output logic              status_chg,
    output logic              tx_busy,
    output logic              txd
);
    import bsync_pkg::*;

    localparam int CRC_W = 2 * CHAR_W;

    logic              hold_full, hold_incl, boundary, need, take;
    logic [CHAR_W-1:0] hold_data, sync_q, crc_lo_q, load_val;
    logic [CRC_W-1:0]  crc;
    logic              lo_pend;
    src_e              src;

    bsync_hold #(.CHAR_W(CHAR_W)) hold_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_data_en), .wr_data(wr_data),
        .wr_incl(wr_crc_incl), .take(take), .full(hold_full),
        .data(hold_data), .incl(hold_incl)
    );

    bsync_crc #(.CHAR_W(CHAR_W), .CRC_W(CRC_W), .POLY(CRC_POLY)) crc_i (
        .clk(clk), .rst_n(rst_n), .acc_en(take && crc_en && hold_incl),
        .acc_byte(hold_data), .clr(need && (src == SRC_CRC_HI)), .crc(crc)
    );

    bsync_shift #(.CHAR_W(CHAR_W)) shift_i (
        .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .tx_en(tx_en),
        .load_val(load_val), .boundary(boundary), .busy(tx_busy), .txd(txd)
    );

    // Purpose: pick the next character source in priority order
    always_comb begin
        if (lo_pend)        src = SRC_CRC_LO;
        else if (hold_full) src = SRC_DATA;
        else if (!eom_flag) src = SRC_CRC_HI;
        else                src = SRC_SYNC;
    end

    // Purpose: select the byte handed to the shifter
    always_comb begin
        unique case (src)
            SRC_DATA:   load_val = hold_data;
            SRC_CRC_HI: load_val = crc[CRC_W-1:CHAR_W];
            SRC_CRC_LO: load_val = crc_lo_q;
            default:    load_val = sync_q;
        endcase
    end

    assign need     = boundary && tx_en;
    assign take     = need && (src == SRC_DATA);
    assign data_req = tx_en && !hold_full;

    // Purpose: programmable fill character
    always_ff @(posedge clk) begin
        if (!rst_n)          sync_q <= SYNC_INIT;
        else if (wr_sync_en) sync_q <= wr_sync;
    end

    // Purpose: hold the CRC low byte between the two trailer characters
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lo_pend  <= 1'b0;
            crc_lo_q <= '0;
        end else if (need && (src == SRC_CRC_HI)) begin
            lo_pend  <= 1'b1;
            crc_lo_q <= crc[CHAR_W-1:0];
        end else if (need && (src == SRC_CRC_LO)) begin
            lo_pend  <= 1'b0;
        end
    end

    // Purpose: end-of-message latch and completion pulse; set beats clear
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            eom_flag   <= 1'b1;
            status_chg <= 1'b0;
        end else begin
            status_chg <= need && (src == SRC_CRC_LO);
            if (need && (src == SRC_CRC_LO)) eom_flag <= 1'b1;
            else if (eom_reset)              eom_flag <= 1'b0;
        end
    end
endmodule

// File: rtl/bsync_tx_chk.sv
// Module: property checker for bsync_tx, attached by bind.
// Assumes: port names match the top module.
module bsync_tx_chk (
    input logic clk,
    input logic rst_n,
    input logic bit_en,
    input logic tx_en,
    input logic wr_data_en,
    input logic eom_reset,
    input logic data_req,
    input logic eom_flag,
    input logic status_chg,
    input logic tx_busy,
    input logic txd
);
    // R4
    wr_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_data_en && data_req) |=> !data_req);

    // R7
    pulse_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
        status_chg |=> !status_chg);

    // R7
    eom_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(eom_flag) |-> status_chg);

    // R6
    eom_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        eom_reset |=> (!eom_flag || status_chg));

    // R10
    idle_stay_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!tx_busy && !tx_en) |=> !tx_busy);

    // R5
    txd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !bit_en |=> $stable(txd));
endmodule

bind bsync_tx bsync_tx_chk chk_i (.*);

// File: tb/bsync_tx_tb_top.sv
// Bench: scoreboard for bsync_tx. Drivers queue the expected characters,
// a monitor rebuilds characters from txd and compares them in order.
module bsync_tx_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bit_en = 1'b0;
    logic       tx_en = 1'b0, crc_en = 1'b0;
    logic       wr_data_en = 1'b0, wr_crc_incl = 1'b0, wr_sync_en = 1'b0;
    logic [7:0] wr_data = '0, wr_sync = '0;
    logic       eom_reset = 1'b0;
    logic       data_req, eom_flag, status_chg, tx_busy, txd;

    int         n_run = 0, n_fail = 0;
    bit         done = 1'b0;

    typedef struct { logic [7:0] val; string tag; } item_t;
    item_t      exp_q[$];
    logic [7:0] cur_sync = 8'h16;
    logic [15:0] crc_m = '0;
    int         fill_cnt = 0, pulse_cnt = 0;

    bsync_tx dut_i (.*);

    always #5 clk = ~clk;

    // bit clock: one pulse every 4 cycles, changed 2 ns after the edge
    initial begin
        int k = 0;
        forever begin
            @(posedge clk); #2;
            bit_en = (k == 3);
            k = (k + 1) % 4;
        end
    end

    task automatic check(bit ok, string tag, string what, int act, int expv);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, expv);
        end
    endtask

    function automatic logic [15:0] crc_add(logic [15:0] c, logic [7:0] b);
        for (int i = 0; i < 8; i++) begin
            logic fb = b[i] ^ c[15];
            c = {c[14:0], 1'b0};
            if (fb) c = c ^ 16'h8005;
        end
        return c;
    endfunction

    // monitor: rebuild characters and score them
    initial begin
        logic [7:0] rx = '0;
        int nb = 0;
        logic was_busy = 1'b0;
        forever begin
            @(negedge clk);
            if (!rst_n) continue;
            if (status_chg) pulse_cnt++;
            if (was_busy && !tx_busy)
                check(nb == 0, "R10", "char cut short, bits", nb, 0);
            if (!tx_busy) nb = 0;
            was_busy = tx_busy;
            if (bit_en && tx_busy) begin
                rx = {txd, rx[7:1]};
                nb++;
                if (nb == 8) begin
                    nb = 0;
                    if (exp_q.size() > 0 && rx == exp_q[0].val) begin
                        check(1'b1, exp_q[0].tag, "char", rx, exp_q[0].val);
                        void'(exp_q.pop_front());
                    end else if (rx == cur_sync) begin
                        fill_cnt++;
                    end else if (exp_q.size() > 0) begin
                        check(1'b0, exp_q[0].tag, "char", rx, exp_q[0].val);
                        void'(exp_q.pop_front());
                    end else begin
                        check(1'b0, "R9", "unexpected char", rx, cur_sync);
                    end
                end
            end
        end
    end

    task automatic send(logic [7:0] b, bit incl, string tag);
        do @(negedge clk); while (!data_req);
        exp_q.push_back('{b, tag});
        if (crc_en && incl) crc_m = crc_add(crc_m, b);
        @(posedge clk); #2;
        wr_data_en = 1'b1; wr_data = b; wr_crc_incl = incl;
        @(posedge clk); #2;
        wr_data_en = 1'b0;
        #3 check(!data_req, "R4", "data_req after write", data_req, 0);
    endtask

    task automatic end_msg(bit expect_crc);
        @(posedge clk); #2 eom_reset = 1'b1;
        @(posedge clk); #2 eom_reset = 1'b0;
        if (expect_crc) begin
            exp_q.push_back('{crc_m[15:8], "R3"});
            exp_q.push_back('{crc_m[7:0],  "R6"});
            crc_m = '0;
        end
    endtask

    task automatic drain();
        do @(negedge clk); while (exp_q.size() != 0 || !eom_flag);
        repeat (40) @(negedge clk);
    endtask

    initial begin
        int p0;
        repeat (3) @(posedge clk);
        #1;
        check(txd == 1'b1,     "R1", "txd",      txd, 1);
        check(tx_busy == 1'b0, "R1", "tx_busy",  tx_busy, 0);
        check(eom_flag == 1'b1, "R1", "eom_flag", eom_flag, 1);
        check(data_req == 1'b0, "R1", "data_req", data_req, 0);
        @(posedge clk); #2 rst_n = 1'b1;

        // sync fill after enable
        @(posedge clk); #2 tx_en = 1'b1;
        repeat (120) @(negedge clk);
        check(fill_cnt >= 2, "R2", "fill count", fill_cnt, 2);
        check(fill_cnt >= 2, "R11", "reset sync 0x16 fill", fill_cnt, 2);
        check(data_req == 1'b1, "R4", "data_req idle", data_req, 1);

        // message with CRC over all bytes
        p0 = pulse_cnt;
        crc_en = 1'b1;
        send(8'h41, 1'b1, "R5");
        send(8'h42, 1'b1, "R5");
        send(8'h43, 1'b1, "R5");
        end_msg(1'b1);
        drain();
        check(pulse_cnt - p0 == 1, "R7", "status pulses", pulse_cnt - p0, 1);
        check(eom_flag == 1'b1, "R7", "eom after crc", eom_flag, 1);
        p0 = fill_cnt;
        repeat (100) @(negedge clk);
        check(fill_cnt > p0, "R7", "fill after crc", fill_cnt - p0, 1);

        // message with one excluded byte
        p0 = pulse_cnt;
        send(8'h10, 1'b0, "R8");
        send(8'h55, 1'b1, "R8");
        send(8'hAA, 1'b1, "R8");
        end_msg(1'b1);
        drain();
        check(pulse_cnt - p0 == 1, "R7", "status pulses msg2", pulse_cnt - p0, 1);

        // CRC disabled: trailer is zero
        crc_en = 1'b0;
        send(8'h99, 1'b1, "R3");
        end_msg(1'b1);
        drain();

        // write while full is dropped; underrun with latch set gives sync only
        do @(negedge clk); while (!data_req);
        exp_q.push_back('{8'h61, "R9"});
        @(posedge clk); #2;
        wr_data_en = 1'b1; wr_data = 8'h61; wr_crc_incl = 1'b1;
        @(posedge clk); #2 wr_data = 8'h62;
        @(posedge clk); #2 wr_data_en = 1'b0;
        p0 = pulse_cnt;
        repeat (200) @(negedge clk);
        check(exp_q.size() == 0, "R9", "pending items", exp_q.size(), 0);
        check(pulse_cnt == p0, "R9", "no crc pulse", pulse_cnt - p0, 0);

        // disable: finish character, idle high
        @(posedge clk); #2 tx_en = 1'b0;
        repeat (60) @(negedge clk);
        check(tx_busy == 1'b0, "R10", "tx_busy idle", tx_busy, 0);
        check(txd == 1'b1, "R10", "txd idle", txd, 1);
        check(data_req == 1'b0, "R4", "data_req disabled", data_req, 0);

        // new sync character
        @(posedge clk); #2 wr_sync_en = 1'b1; wr_sync = 8'h7E;
        @(posedge clk); #2 wr_sync_en = 1'b0;
        cur_sync = 8'h7E;
        p0 = fill_cnt;
        tx_en = 1'b1;
        repeat (150) @(negedge clk);
        check(fill_cnt - p0 >= 3, "R11", "fill with 0x7E", fill_cnt - p0, 3);
        send(8'h33, 1'b1, "R5");
        drain();

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_run++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end
endmodule